// File: doc/BRIEF.md
# TLB Control Register Front End

This block is the software-visible face of a translation lookaside buffer. Software reaches three 32-bit control registers over a small register bus: an entry-address register that carries the virtual page number, an access register that carries the frame number and permission bits, and a control register that carries the process ID, the target way and two command flags. The block turns register writes into write and read operations on an external TLB array.

An install starts when software writes the access register while the write-enable flag is set in the control register's read-back value. The block then drives the array's write port with an entry built from the last written page number, the last written process ID and the bits of the access write. After the install it advances the way field, so that successive installs land in successive ways. A fetch starts when software writes the control register with the read flag set. The block addresses the array with the written way and the last written page number. One cycle later it loads the returned entry into the read-back values of all three registers.

Each register keeps two values. One is the shadow value that software last wrote, which is used for indexing and for building entries. The other is the read-back value that software sees. The two differ where the rules below say so.

Top module: `tlbctl_front`

## Requirements
- R1: After reset the three read-back values are zero, `busy` is low and neither `tlb_we` nor `tlb_re` is asserted.
- R2: An access-register write (address 1) asserts `tlb_we` in the same cycle only when bit 18 (write enable) of the control register's read-back value is set. The target index is way × SETS + (page number mod SETS). The way comes from bits 20 and up of the control read-back value. The fields are: frame number = write data [19:0], flags {C,R,W,X} = write data [23:20], global = write data [24].
- R3: Each install advances the way field of the control read-back value by one, modulo the number of ways.
- R4: An access-register write never changes the access register's read-back value.
- R5: An entry-address write (address 0) updates every bit of its read-back value except the page-number field [21:2], which keeps its previous value. The written page number is still used as the shadow for indexing.
- R6: An installed entry is marked valid only when its page number is below 0xC0000, meaning its top two bits are not both one.
- R7: A control-register write (address 2) with bit 19 (read flag) set asserts `tlb_re` in the same cycle. The index is the written way × SETS + (shadow page number mod SETS). `busy` is high for the following cycle.
- R8: At the end of the busy cycle, the entry is loaded into the read-back values. The access register becomes {bits [31:25] kept, global at 24, {C,R,W,X} at [23:20], frame at [19:0]}. The control register's process-ID field [4 +: PID_W] takes the entry's process ID. The entry-address register's page-number field takes the entry's page number.
- R9: A control-register write is stored as written into the read-back value, apart from the later fetch patch. A read returns the read-back value of the addressed register in the same cycle, and address 3 returns zero.
- R10: Installs take their process ID from the last written control value, even after a fetch has replaced the process ID seen on read-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 2 | Register select: 0 entry address, 1 access, 2 control |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 32 | Read-back value of the selected register |
| busy | output | 1 | Fetch in progress, read-back values update at its end |
| tlb_we | output | 1 | Array write strobe |
| tlb_widx | output | IDX_W | Array write index |
| tlb_wvpn | output | 20 | Page number of entry being written |
| tlb_wpid | output | PID_W | Process ID of entry being written |
| tlb_wglobal | output | 1 | Global flag of entry being written |
| tlb_wvalid | output | 1 | Valid flag of entry being written |
| tlb_wflags | output | 4 | {C,R,W,X} of entry being written |
| tlb_wpfn | output | 20 | Frame number of entry being written |
| tlb_re | output | 1 | Array read strobe |
| tlb_ridx | output | IDX_W | Array read index |
| tlb_rvpn | input | 20 | Page number returned by the array one cycle after `tlb_re` |
| tlb_rpid | input | PID_W | Process ID returned by the array |
| tlb_rglobal | input | 1 | Global flag returned by the array |
| tlb_rflags | input | 4 | {C,R,W,X} returned by the array |
| tlb_rpfn | input | 20 | Frame number returned by the array |

## Verification
The array strobes and indices are combinational, so they are due in the same cycle as the register write. The bench samples them a short delay after driving the write, and a monitor compares each observed install against a queue of expected entries. Register updates and `busy` are due after one clock edge. Fetched values are due after two edges from the start of the triggering write. The bench therefore checks `busy` at the first falling edge after the write and the read-back values at the second. An expected install is pushed before its access write, and the queue must be empty at the end.

// File: rtl/tlbctl_pkg.sv
package tlbctl_pkg;
  localparam int REG_W        = 32;
  localparam int VPN_W        = 20;
  localparam int PFN_W        = 20;
  localparam int PTE_VPN_LSB  = 2;
  localparam int CTL_PID_LSB  = 4;
  localparam int CTL_WE_BIT   = 18;
  localparam int CTL_RD_BIT   = 19;
  localparam int CTL_WAY_LSB  = 20;
  localparam int ACC_FLAG_LSB = 20;
  localparam int ACC_GLB_BIT  = 24;
  localparam int ACC_KEEP_LSB = 25;

  localparam logic [1:0] SEL_PTE = 2'd0;
  localparam logic [1:0] SEL_ACC = 2'd1;
  localparam logic [1:0] SEL_CTL = 2'd2;

  localparam logic [REG_W-1:0] PTE_VPN_MASK = 32'h003F_FFFC;

  // A page is mappable unless it lies in the top quarter of the page space.
  function automatic logic page_mappable(input logic [VPN_W-1:0] vpn);
    return vpn[VPN_W-1 -: 2] != 2'b11;
  endfunction

  // Entry-address write: page-number field keeps its previous read-back.
  function automatic logic [REG_W-1:0] pte_merge(input logic [REG_W-1:0] wr,
                                                 input logic [REG_W-1:0] old);
    return (wr & ~PTE_VPN_MASK) | (old & PTE_VPN_MASK);
  endfunction
endpackage

// File: rtl/tlbctl_writer.sv
module tlbctl_writer
  import tlbctl_pkg::*;
#(
  parameter int PID_W = 8,
  parameter int WAY_W = 2,
  parameter int SET_W = 4
) (
  input  logic                   acc_wr,
  input  logic                   ctl_we_flag,
  input  logic [WAY_W-1:0]       way,
  input  logic [VPN_W-1:0]       vpn_sh,
  input  logic [PID_W-1:0]       pid_sh,
  input  logic                   glb,
  input  logic [3:0]             flags,
  input  logic [PFN_W-1:0]       pfn,
  output logic                   we,
  output logic [WAY_W+SET_W-1:0] idx,
  output logic [VPN_W-1:0]       o_vpn,
  output logic [PID_W-1:0]       o_pid,
  output logic                   o_glb,
  output logic                   o_valid,
  output logic [3:0]             o_flags,
  output logic [PFN_W-1:0]       o_pfn,
  output logic [WAY_W-1:0]       way_next
);
  always_comb begin
    we       = acc_wr && ctl_we_flag;
    idx      = {way, vpn_sh[SET_W-1:0]};
    o_vpn    = vpn_sh;
    o_pid    = pid_sh;
    o_glb    = glb;
    o_valid  = page_mappable(vpn_sh);
    o_flags  = flags;
    o_pfn    = pfn;
    way_next = way + 1'b1;
  end
endmodule

// File: rtl/tlbctl_reader.sv
module tlbctl_reader #(
  parameter int WAY_W = 2,
  parameter int SET_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   trig,
  input  logic [WAY_W-1:0]       way,
  input  logic [SET_W-1:0]       set_sh,
  output logic                   re,
  output logic [WAY_W+SET_W-1:0] idx,
  output logic                   load
);
  assign re  = trig;
  assign idx = {way, set_sh};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load <= 1'b0;
    else        load <= trig;
  end

  p_busy_after_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> load);
  p_busy_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !trig |=> !load);
endmodule

// File: rtl/tlbctl_front.sv
module tlbctl_front
  import tlbctl_pkg::*;
#(
  parameter int PID_W = 8,
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS),
  localparam int IDX_W = WAY_W + SET_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  input  logic             reg_we,
  output logic [31:0]      reg_rdata,
  output logic             busy,
  output logic             tlb_we,
  output logic [IDX_W-1:0] tlb_widx,
  output logic [19:0]      tlb_wvpn,
  output logic [PID_W-1:0] tlb_wpid,
  output logic             tlb_wglobal,
  output logic             tlb_wvalid,
  output logic [3:0]       tlb_wflags,
  output logic [19:0]      tlb_wpfn,
  output logic             tlb_re,
  output logic [IDX_W-1:0] tlb_ridx,
  input  logic [19:0]      tlb_rvpn,
  input  logic [PID_W-1:0] tlb_rpid,
  input  logic             tlb_rglobal,
  input  logic [3:0]       tlb_rflags,
  input  logic [19:0]      tlb_rpfn
);
  logic [REG_W-1:0] pte_rb, acc_rb, ctl_rb;
  logic [VPN_W-1:0] vpn_sh;
  logic [PID_W-1:0] pid_sh;
  logic [WAY_W-1:0] way_next;

  // Named bus events
  logic wr_pte, wr_acc, wr_ctl, fetch_trig;
  assign wr_pte     = reg_we && (reg_addr == SEL_PTE);
  assign wr_acc     = reg_we && (reg_addr == SEL_ACC);
  assign wr_ctl     = reg_we && (reg_addr == SEL_CTL);
  assign fetch_trig = wr_ctl && reg_wdata[CTL_RD_BIT];

  tlbctl_writer #(.PID_W(PID_W), .WAY_W(WAY_W), .SET_W(SET_W)) u_writer (
    .acc_wr      (wr_acc),
    .ctl_we_flag (ctl_rb[CTL_WE_BIT]),
    .way         (ctl_rb[CTL_WAY_LSB +: WAY_W]),
    .vpn_sh      (vpn_sh),
    .pid_sh      (pid_sh),
    .glb         (reg_wdata[ACC_GLB_BIT]),
    .flags       (reg_wdata[ACC_FLAG_LSB +: 4]),
    .pfn         (reg_wdata[PFN_W-1:0]),
    .we          (tlb_we),
    .idx         (tlb_widx),
    .o_vpn       (tlb_wvpn),
    .o_pid       (tlb_wpid),
    .o_glb       (tlb_wglobal),
    .o_valid     (tlb_wvalid),
    .o_flags     (tlb_wflags),
    .o_pfn       (tlb_wpfn),
    .way_next    (way_next)
  );

  tlbctl_reader #(.WAY_W(WAY_W), .SET_W(SET_W)) u_reader (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig   (fetch_trig),
    .way    (reg_wdata[CTL_WAY_LSB +: WAY_W]),
    .set_sh (vpn_sh[SET_W-1:0]),
    .re     (tlb_re),
    .idx    (tlb_ridx),
    .load   (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pte_rb <= '0;
      acc_rb <= '0;
      ctl_rb <= '0;
      vpn_sh <= '0;
      pid_sh <= '0;
    end else begin
      if (wr_pte) begin
        pte_rb <= pte_merge(reg_wdata, pte_rb);
        vpn_sh <= reg_wdata[PTE_VPN_LSB +: VPN_W];
      end
      if (wr_ctl) begin
        ctl_rb <= reg_wdata;
        pid_sh <= reg_wdata[CTL_PID_LSB +: PID_W];
      end
      if (tlb_we) ctl_rb[CTL_WAY_LSB +: WAY_W] <= way_next;
      if (busy) begin
        acc_rb <= {acc_rb[REG_W-1:ACC_KEEP_LSB], tlb_rglobal, tlb_rflags, tlb_rpfn};
        ctl_rb[CTL_PID_LSB +: PID_W] <= tlb_rpid;
        pte_rb[PTE_VPN_LSB +: VPN_W] <= tlb_rvpn;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      SEL_PTE: reg_rdata = pte_rb;
      SEL_ACC: reg_rdata = acc_rb;
      SEL_CTL: reg_rdata = ctl_rb;
      default: reg_rdata = '0;
    endcase
  end

  p_install_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_we |-> (reg_we && reg_addr == SEL_ACC && ctl_rb[CTL_WE_BIT]));
  p_way_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_we |=> (ctl_rb[CTL_WAY_LSB +: WAY_W] ==
                WAY_W'($past(ctl_rb[CTL_WAY_LSB +: WAY_W]) + 1'b1)));
  p_acc_readback_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && !busy) |=> $stable(acc_rb));
  p_pte_page_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pte && !busy) |=> $stable(pte_rb[PTE_VPN_LSB +: VPN_W]));
  p_unmappable_invalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_we && tlb_wvpn[19:18] == 2'b11) |-> !tlb_wvalid);
  p_fetch_pid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_ctl) |=> (ctl_rb[CTL_PID_LSB +: PID_W] == $past(tlb_rpid)));
endmodule

// File: tb/tlbctl_front_test.sv
module tlbctl_front_test;
  localparam int PID_W = 8;
  localparam int IDX_W = 6;
  localparam int TW = IDX_W + 20 + PID_W + 1 + 1 + 4 + 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic reg_we = 1'b0, busy;
  logic tlb_we, tlb_wglobal, tlb_wvalid, tlb_re, tlb_rglobal;
  logic [IDX_W-1:0] tlb_widx, tlb_ridx;
  logic [19:0] tlb_wvpn, tlb_wpfn, tlb_rvpn, tlb_rpfn;
  logic [PID_W-1:0] tlb_wpid, tlb_rpid;
  logic [3:0] tlb_wflags, tlb_rflags;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [TW-1:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  tlbctl_front uut (.*);

  // Array model with registered read
  logic [19:0] m_vpn[64], m_pfn[64];
  logic [PID_W-1:0] m_pid[64];
  logic m_g[64];
  logic [3:0] m_fl[64];
  always @(posedge clk) begin
    if (tlb_we) begin
      m_vpn[tlb_widx] <= tlb_wvpn; m_pfn[tlb_widx] <= tlb_wpfn;
      m_pid[tlb_widx] <= tlb_wpid; m_g[tlb_widx] <= tlb_wglobal;
      m_fl[tlb_widx] <= tlb_wflags;
    end
    if (tlb_re) begin
      tlb_rvpn <= m_vpn[tlb_ridx]; tlb_rpfn <= m_pfn[tlb_ridx];
      tlb_rpid <= m_pid[tlb_ridx]; tlb_rglobal <= m_g[tlb_ridx];
      tlb_rflags <= m_fl[tlb_ridx];
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] entry(int way, logic [19:0] vpn, logic [7:0] pid,
      logic g, logic v, logic [3:0] fl, logic [19:0] pfn);
    logic [IDX_W-1:0] idx = IDX_W'(way * 16 + (vpn % 16));
    return {idx, vpn, pid, g, v, fl, pfn};
  endfunction

  // Monitor: every install is compared with the next expected one
  initial forever begin
    @(negedge clk); #2;
    if (rst_n && tlb_we) begin
      if (exp_q.size() == 0) chk("R2 unexpected install", 1, 0);
      else chk(tag_q.pop_front(), {tlb_widx, tlb_wvpn, tlb_wpid, tlb_wglobal,
               tlb_wvalid, tlb_wflags, tlb_wpfn}, exp_q.pop_front());
    end
  end

  task automatic drive(logic [1:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1; #1;
  endtask
  task automatic wr(logic [1:0] a, logic [31:0] d);
    drive(a, d); @(negedge clk); reg_we = 1'b0;
  endtask
  task automatic install(logic [31:0] d, logic [TW-1:0] e, string tag);
    exp_q.push_back(e); tag_q.push_back(tag); wr(2'd1, d);
  endtask
  task automatic rd(logic [1:0] a, logic [31:0] exp, string tag);
    @(negedge clk); reg_addr = a; #1; chk(tag, reg_rdata, exp);
  endtask
  task automatic fetch(logic [31:0] d, int ridx, string tag);
    drive(2'd2, d);
    chk({tag, " tlb_re"}, tlb_re, 1); chk({tag, " ridx"}, tlb_ridx, ridx);
    @(negedge clk); reg_we = 1'b0; chk({tag, " busy"}, busy, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(0, 0, "R1 pte"); rd(1, 0, "R1 acc"); rd(2, 0, "R1 ctl");
    chk("R1 busy/we/re", {busy, tlb_we, tlb_re}, 0);
    // R5 page-number field keeps old read-back
    wr(0, 32'h8000_0123); rd(0, 32'h8000_0003, "R5 pte merge");
    // R9 control stored as written
    wr(2, 32'h0014_05A0); rd(2, 32'h0014_05A0, "R9 ctl as written");
    rd(3, 0, "R9 addr3 zero");
    // R2 install into way 1, page 0x48
    install(32'h01B1_2345, entry(1, 20'h48, 8'h5A, 1, 1, 4'hB, 20'h12345), "R2 install way1");
    rd(1, 0, "R4 acc unchanged"); rd(2, 32'h0024_05A0, "R3 way advanced");
    install(32'h0000_0001, entry(2, 20'h48, 8'h5A, 0, 1, 4'h0, 20'h00001), "R3 install way2");
    install(32'h0060_ABCD, entry(3, 20'h48, 8'h5A, 0, 1, 4'h6, 20'h0ABCD), "R3 install way3");
    install(32'h0100_0FFF, entry(0, 20'h48, 8'h5A, 1, 1, 4'h0, 20'h00FFF), "R3 install wrap way0");
    rd(2, 32'h0014_05A0, "R3 way wrapped");
    // R2 no install without write-enable
    wr(2, 32'h0000_05A0);
    drive(1, 32'h00F1_1111); chk("R2 no install", tlb_we, 0);
    @(negedge clk); reg_we = 1'b0;
    rd(2, 32'h0000_05A0, "R2 way unchanged"); rd(1, 0, "R4 acc still zero");
    // R6 unmappable page
    wr(2, 32'h0004_0330); wr(0, 32'h0030_0014);
    install(32'h0000_0001, entry(0, 20'hC0005, 8'h33, 0, 0, 4'h0, 20'h00001), "R6 invalid entry");
    rd(0, 32'h0000_0000, "R5 pte merge 2");
    // R7/R8 fetch way 3
    wr(0, 32'h8000_0123); rd(0, 32'h8000_0003, "R5 pte merge 3");
    fetch(32'h0038_0770, 56, "R7 fetch way3");
    rd(1, 32'h0060_ABCD, "R8 acc loaded"); chk("R7 busy cleared", busy, 0);
    rd(2, 32'h0038_05A0, "R8 ctl pid patched"); rd(0, 32'h8000_0123, "R8 pte page patched");
    // R8 global entry, then R10 shadow PID on install
    fetch(32'h001C_0770, 24, "R7 fetch way1");
    rd(1, 32'h01B1_2345, "R8 acc global"); rd(2, 32'h001C_05A0, "R8 ctl pid way1");
    install(32'h0070_0042, entry(1, 20'h48, 8'h77, 0, 1, 4'h7, 20'h00042), "R10 shadow pid");
    rd(2, 32'h002C_05A0, "R3 way after fetch"); rd(1, 32'h01B1_2345, "R4 acc kept");
    repeat (2) @(negedge clk);
    chk("R2 all installs seen", exp_q.size(), 0);
    finish_run();
  end
endmodule